// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Pending Logic

This block collects interrupt events from two serial channels and turns them into a combined pending register and a single request line. Each channel reports three kinds of event. The first is receive activity: a character arriving, or a special condition. The second is its transmit buffer going empty. The third is any change on its external status lines. Per-channel enables decide which events may raise a pending bit. A shared master enable decides whether pending bits reach the request output.

The register decoder sends one-cycle clear commands. These retire a channel's receive, transmit or status pending bit. A re-arm command restores the first-character receive mode. Channel A is index 0 on every per-channel port and channel B is index 1. Every event input is a one-cycle pulse, except the status line levels. Pending bits and the request are registered. An event in cycle N shows on `pend` and `irq` after the clock edge that ends cycle N.

Top module: `irq_pend_top`

## Requirements
- R1: With receive mode 2'b10, every `rx_char` pulse sets the channel's receive pending bit. Any special condition also sets it.
- R2: With receive mode 2'b01, the first `rx_char` after reset or after `rearm_rx` sets receive pending. Later characters are ignored until the next `rearm_rx`. Special conditions always set it.
- R3: With receive mode 2'b11, `rx_char` alone never sets receive pending. A special condition does.
- R4: With receive mode 2'b00, nothing sets receive pending, including special conditions.
- R5: `rx_err` bits {end of frame, framing, overrun} are always special conditions. `rx_par` is a special condition only while the channel's `par_sc` is 1.
- R6: A `tx_empty` pulse sets the transmit pending bit only while `tx_ie` is 1.
- R7: While `ext_ie` is 1, a rising or falling change on an `ext_lvl` bit sets the status pending bit. The bit must be enabled in `ext_en`, and only bits 7, 6, 5, 4, 3 and 1 are valid sources. Bits 2 and 0 are ignored. Levels present during reset are taken as the baseline and raise nothing.
- R8: The `pend` layout is bit 5 A receive, 4 A transmit, 3 A status, 2 B receive, 1 B transmit, 0 B status. Bits 7:6 read 0.
- R9: `clr_rx`, `clr_tx` and `clr_ext` clear only the addressed channel's matching bit. A new event for that bit in the same cycle wins, and the bit stays set.
- R10: `irq` is registered. It is 1 one cycle after a cycle in which `master_ie` is 1 and some pending bit has its enable set. A receive bit counts as enabled when its mode is nonzero, a transmit bit when `tx_ie` is 1, and a status bit when `ext_ie` is 1.
- R11: During and right after reset, `pend` and `irq` are 0 and first-character mode is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_ie | input | 1 | Master interrupt enable |
| rx_mode | input | 2x2 | Per-channel receive interrupt mode |
| par_sc | input | 2 | Per-channel: parity error counts as special condition |
| tx_ie | input | 2 | Per-channel transmit interrupt enable |
| ext_ie | input | 2 | Per-channel status interrupt enable |
| ext_en | input | 2x8 | Per-channel status source enables |
| rx_char | input | 2 | Character received pulse |
| rx_err | input | 2x3 | {end of frame, framing, overrun} pulses |
| rx_par | input | 2 | Parity error pulse |
| tx_empty | input | 2 | Transmit buffer became empty pulse |
| ext_lvl | input | 2x8 | Status line levels |
| clr_rx | input | 2 | Clear receive pending command |
| clr_tx | input | 2 | Clear transmit pending command |
| clr_ext | input | 2 | Clear status pending command |
| rearm_rx | input | 2 | Re-arm first-character receive mode |
| pend | output | 8 | Combined pending register |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- a disabled transmit or receive mode never raises a bit;
- special-only mode ignores plain characters;
- a clear without a competing event empties its bit;
- a transmit event with its enable set always lands;
- the request is silent without the master enable and never stands over an empty register.

Other behaviour needs a sequence of events, so only the bench scenarios can show it:
- first-character mode going quiet after one interrupt and waking on re-arm;
- either-edge detection against the baseline taken during reset;
- the ignored status bits;
- the parity qualification;
- the exact bit layout when both channels fire together.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NCH    = 2;
  localparam int EXT_W  = 8;
  localparam int PEND_W = 8;
  localparam logic [EXT_W-1:0] EXT_VALID = 8'hFA;

  typedef enum logic [1:0] {
    RXI_OFF     = 2'b00,
    RXI_FIRST   = 2'b01,
    RXI_ALL     = 2'b10,
    RXI_SPECIAL = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic rx;
    logic tx;
    logic st;
  } chan_pend_t;
endpackage

// File: rtl/irq_ext_edge.sv
module irq_ext_edge
  import irq_pkg::*;
#(
  parameter int W = EXT_W,
  parameter logic [W-1:0] VALID = EXT_VALID
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         grp_en,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] src_en,
  output logic         hit
);
  logic [W-1:0] prev_q;

  // Baseline follows the lines even during reset, so release gives no edge
  always_ff @(posedge clk) begin
    prev_q <= lvl;
  end

  assign hit = grp_en & |((lvl ^ prev_q) & src_en & VALID);

  // R7
  ext_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(lvl) && !rst) |-> !hit);
endmodule

// File: rtl/irq_rx_qual.sv
module irq_rx_qual
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       par_sc,
  input  logic       char_in,
  input  logic [2:0] err,
  input  logic       par_err,
  input  logic       rearm,
  output logic       rx_ev
);
  rx_mode_e mode_e;
  logic     special;
  logic     armed_q;

  assign mode_e  = rx_mode_e'(mode);
  assign special = (|err) | (par_err & par_sc);

  always_comb begin
    unique case (mode_e)
      RXI_OFF:     rx_ev = 1'b0;
      RXI_FIRST:   rx_ev = (char_in & armed_q) | special;
      RXI_ALL:     rx_ev = char_in | special;
      RXI_SPECIAL: rx_ev = special;
      default:     rx_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                                          armed_q <= 1'b1;
    else if (rearm)                                   armed_q <= 1'b1;
    else if (mode_e == RXI_FIRST && char_in)          armed_q <= 1'b0;
  end

  // R2
  first_once_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && char_in && !rearm) |=> !armed_q);

  // R2
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    rearm |=> armed_q);
endmodule

// File: rtl/irq_chan.sv
module irq_chan
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rx_mode,
  input  logic             par_sc,
  input  logic             tx_ie,
  input  logic             ext_ie,
  input  logic [EXT_W-1:0] ext_en,
  input  logic             rx_char,
  input  logic [2:0]       rx_err,
  input  logic             rx_par,
  input  logic             tx_empty,
  input  logic [EXT_W-1:0] ext_lvl,
  input  logic             clr_rx,
  input  logic             clr_tx,
  input  logic             clr_ext,
  input  logic             rearm_rx,
  output chan_pend_t       pend_q,
  output chan_pend_t       pend_d,
  output chan_pend_t       en_mask
);
  logic rx_ev, tx_ev, st_ev;

  irq_rx_qual u_rxq (
    .clk     (clk),
    .rst     (rst),
    .mode    (rx_mode),
    .par_sc  (par_sc),
    .char_in (rx_char),
    .err     (rx_err),
    .par_err (rx_par),
    .rearm   (rearm_rx),
    .rx_ev   (rx_ev)
  );

  irq_ext_edge #(.W(EXT_W), .VALID(EXT_VALID)) u_ext (
    .clk    (clk),
    .rst    (rst),
    .grp_en (ext_ie),
    .lvl    (ext_lvl),
    .src_en (ext_en),
    .hit    (st_ev)
  );

  assign tx_ev = tx_empty & tx_ie;

  // New events win over same-cycle clears
  always_comb begin
    pend_d.rx = rx_ev | (pend_q.rx & ~clr_rx);
    pend_d.tx = tx_ev | (pend_q.tx & ~clr_tx);
    pend_d.st = st_ev | (pend_q.st & ~clr_ext);
  end

  assign en_mask.rx = (rx_mode != 2'b00);
  assign en_mask.tx = tx_ie;
  assign en_mask.st = ext_ie;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // R9
  clr_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_rx && !rx_ev) |=> !pend_q.rx);

  // R9
  clr_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_tx && !tx_empty) |=> !pend_q.tx);

  // R4
  rx_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_mode == 2'b00 && !pend_q.rx) |=> !pend_q.rx);

  // R3
  special_only_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_mode == 2'b11 && rx_err == 3'b000 && !rx_par && !pend_q.rx) |=> !pend_q.rx);

  // R6
  tx_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && tx_ie) |=> pend_q.tx);

  // R6
  tx_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_ie && !pend_q.tx) |=> !pend_q.tx);
endmodule

// File: rtl/irq_pend_top.sv
module irq_pend_top
  import irq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       master_ie,
  input  logic [NCH-1:0][1:0]        rx_mode,
  input  logic [NCH-1:0]             par_sc,
  input  logic [NCH-1:0]             tx_ie,
  input  logic [NCH-1:0]             ext_ie,
  input  logic [NCH-1:0][EXT_W-1:0]  ext_en,
  input  logic [NCH-1:0]             rx_char,
  input  logic [NCH-1:0][2:0]        rx_err,
  input  logic [NCH-1:0]             rx_par,
  input  logic [NCH-1:0]             tx_empty,
  input  logic [NCH-1:0][EXT_W-1:0]  ext_lvl,
  input  logic [NCH-1:0]             clr_rx,
  input  logic [NCH-1:0]             clr_tx,
  input  logic [NCH-1:0]             clr_ext,
  input  logic [NCH-1:0]             rearm_rx,
  output logic [PEND_W-1:0]          pend,
  output logic                       irq
);
  localparam int USED = 3 * NCH;

  logic [PEND_W-1:0] pend_nxt;
  logic [PEND_W-1:0] en_vec;
  logic              irq_q;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int BASE = 3 * (NCH - 1 - c);
      chan_pend_t q, d, m;

      irq_chan u_chan (
        .clk      (clk),
        .rst      (rst),
        .rx_mode  (rx_mode[c]),
        .par_sc   (par_sc[c]),
        .tx_ie    (tx_ie[c]),
        .ext_ie   (ext_ie[c]),
        .ext_en   (ext_en[c]),
        .rx_char  (rx_char[c]),
        .rx_err   (rx_err[c]),
        .rx_par   (rx_par[c]),
        .tx_empty (tx_empty[c]),
        .ext_lvl  (ext_lvl[c]),
        .clr_rx   (clr_rx[c]),
        .clr_tx   (clr_tx[c]),
        .clr_ext  (clr_ext[c]),
        .rearm_rx (rearm_rx[c]),
        .pend_q   (q),
        .pend_d   (d),
        .en_mask  (m)
      );

      assign pend[BASE+2:BASE]     = {q.rx, q.tx, q.st};
      assign pend_nxt[BASE+2:BASE] = {d.rx, d.tx, d.st};
      assign en_vec[BASE+2:BASE]   = {m.rx, m.tx, m.st};
    end

    if (PEND_W > USED) begin : g_pad
      assign pend[PEND_W-1:USED]     = '0;
      assign pend_nxt[PEND_W-1:USED] = '0;
      assign en_vec[PEND_W-1:USED]   = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= master_ie & |(pend_nxt & en_vec);
  end

  assign irq = irq_q;

  // R10
  master_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !master_ie |=> !irq);

  // R10
  irq_backed_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|pend));
endmodule

// File: tb/irq_pend_top_tb.sv
`timescale 1ns/1ps
module irq_pend_top_tb;
  import irq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic                      master_ie;
  logic [NCH-1:0][1:0]       rx_mode;
  logic [NCH-1:0]            par_sc, tx_ie, ext_ie;
  logic [NCH-1:0][EXT_W-1:0] ext_en, ext_lvl;
  logic [NCH-1:0]            rx_char, rx_par, tx_empty;
  logic [NCH-1:0][2:0]       rx_err;
  logic [NCH-1:0]            clr_rx, clr_tx, clr_ext, rearm_rx;
  logic [PEND_W-1:0]         pend;
  logic                      irq;

  irq_pend_top u_dut (
    .clk(clk), .rst(rst), .master_ie(master_ie), .rx_mode(rx_mode),
    .par_sc(par_sc), .tx_ie(tx_ie), .ext_ie(ext_ie), .ext_en(ext_en),
    .rx_char(rx_char), .rx_err(rx_err), .rx_par(rx_par), .tx_empty(tx_empty),
    .ext_lvl(ext_lvl), .clr_rx(clr_rx), .clr_tx(clr_tx), .clr_ext(clr_ext),
    .rearm_rx(rearm_rx), .pend(pend), .irq(irq)
  );

  typedef struct {
    logic [7:0] p;
    logic       i;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Monitor: compares each registered result one ns after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pend !== e.p || irq !== e.i) begin
        errors++;
        $display("FAIL %s: pend=%h irq=%b expected pend=%h irq=%b",
                 e.tag, pend, irq, e.p, e.i);
      end
    end
  end

  task automatic clear_pulses();
    rx_char = '0; rx_err = '0; rx_par = '0; tx_empty = '0;
    clr_rx = '0; clr_tx = '0; clr_ext = '0; rearm_rx = '0;
  endtask

  // Driver: stimulus already set at a falling edge; queue expectation
  task automatic step(input logic [7:0] p, input logic i, input string tag);
    exp_t e;
    e.p = p; e.i = i; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    clear_pulses();
    master_ie = 1'b1;
    rx_mode   = {2'b10, 2'b10};
    par_sc    = '0;
    tx_ie     = '1;
    ext_ie    = '1;
    ext_en    = {8'hFA, 8'hFA};
    ext_lvl   = '0;
    ext_lvl[0] = 8'h20;              // A CTS high during reset: baseline
    repeat (3) @(negedge clk);
    checks++;
    if (pend !== 8'h00 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R11 in reset: pend=%h irq=%b expected pend=00 irq=0", pend, irq);
    end
    rst = 1'b0;

    step(8'h00, 1'b0, "R11 R7 idle after reset, no baseline edge");
    rx_char[0] = 1'b1;                 step(8'h20, 1'b1, "R1 R8 A char");
    clr_rx[0] = 1'b1;                  step(8'h00, 1'b0, "R9 A clear rx");
    rx_char[1] = 1'b1;                 step(8'h04, 1'b1, "R1 R8 B char");
    clr_rx[1] = 1'b1; rx_char[1] = 1; step(8'h04, 1'b1, "R9 event beats clear");
    clr_rx[1] = 1'b1;                  step(8'h00, 1'b0, "R9 B clear rx");
    rx_mode[0] = 2'b01; rx_char[0] = 1; step(8'h20, 1'b1, "R2 first char");
    clr_rx[0] = 1'b1;                  step(8'h00, 1'b0, "R9 clear");
    rx_char[0] = 1'b1;                 step(8'h00, 1'b0, "R2 second char ignored");
    rx_err[0] = 3'b001;                step(8'h20, 1'b1, "R2 R5 overrun still interrupts");
    clr_rx[0] = 1'b1; rearm_rx[0] = 1; step(8'h00, 1'b0, "R2 rearm alone sets nothing");
    rx_char[0] = 1'b1;                 step(8'h20, 1'b1, "R2 char after rearm");
    clr_rx[0] = 1'b1; rx_mode[0] = 2'b11; step(8'h00, 1'b0, "R9 clear");
    rx_char[0] = 1'b1;                 step(8'h00, 1'b0, "R3 char ignored");
    rx_err[0] = 3'b010;                step(8'h20, 1'b1, "R3 R5 framing sets");
    clr_rx[0] = 1'b1; rx_mode[0] = 2'b00; step(8'h00, 1'b0, "R9 clear");
    rx_err[0] = 3'b100; rx_char[0] = 1; step(8'h00, 1'b0, "R4 mode off");
    rx_mode[0] = 2'b10; rx_par[0] = 1; step(8'h00, 1'b0, "R5 parity not special");
    par_sc[0] = 1'b1; rx_par[0] = 1;   step(8'h20, 1'b1, "R5 parity special");
    clr_rx[0] = 1'b1;                  step(8'h00, 1'b0, "R9 clear");
    tx_empty[1] = 1'b1;                step(8'h02, 1'b1, "R6 R8 B tx");
    tx_ie[0] = 1'b0; tx_empty[0] = 1;  step(8'h02, 1'b1, "R6 A tx masked");
    tx_ie[0] = 1'b1; tx_empty[0] = 1;  step(8'h12, 1'b1, "R6 R8 A tx");
    clr_tx[1] = 1'b1; clr_ext[0] = 1;  step(8'h10, 1'b1, "R9 only B tx cleared");
    clr_tx[0] = 1'b1;                  step(8'h00, 1'b0, "R9 A tx cleared");
    ext_lvl[0] = 8'h00;                step(8'h08, 1'b1, "R7 R8 falling CTS");
    clr_ext[0] = 1'b1;                 step(8'h00, 1'b0, "R9 clear status");
    ext_lvl[0] = 8'h20;                step(8'h08, 1'b1, "R7 rising CTS");
    clr_ext[0] = 1'b1; ext_lvl[0] = 8'h21; step(8'h00, 1'b0, "R7 bit 0 ignored");
    ext_en[0] = 8'hDA; ext_lvl[0] = 8'h01; step(8'h00, 1'b0, "R7 disabled source");
    ext_ie[1] = 1'b0; ext_lvl[1] = 8'h80; step(8'h00, 1'b0, "R7 group disabled");
    ext_ie[1] = 1'b1; ext_lvl[1] = 8'h00; step(8'h01, 1'b1, "R7 R8 B falling break");
    master_ie = 1'b0;                  step(8'h01, 1'b0, "R10 master off");
    master_ie = 1'b1;                  step(8'h01, 1'b1, "R10 master on");
    ext_ie[1] = 1'b0;                  step(8'h01, 1'b0, "R10 pending bit not enabled");
    clr_ext[1] = 1'b1;                 step(8'h00, 1'b0, "R9 B clear status");
    rx_char = 2'b11;                   step(8'h24, 1'b1, "R1 R8 both channels");
    clr_rx = 2'b11;                    step(8'h00, 1'b0, "R9 clear both");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule